// File: doc/BRIEF.md
# Timer With Shared Watchdog Prescaler

This block holds an 8-bit counter, a watchdog, and one divider that is switched between the two. The counter's input is either the instruction-cycle enable or a synchronized transition on an external pin, and a mode bit picks which pin edge counts. The watchdog's input is a base tick from an on-chip RC oscillator, which lies outside this block. One 3-bit ratio code sets the divider. It divides twice as finely when it serves the watchdog as when it serves the counter.

Firmware writes the 6-bit mode register and the counter. It issues a clear-watchdog strobe to keep the watchdog from expiring. A fixed configuration input turns the watchdog on or off. When the counter wraps it gives a one-cycle strobe for the interrupt logic. When the watchdog expires it gives a one-cycle reset pulse and sets a sticky timeout flag.

Top module: `tmr_wdt_unit`

## Requirements
- R1: After reset the counter reads 0, and the overflow strobe, reset pulse and timeout flag are low. The mode resets to pin source, falling edge, divider to watchdog and ratio 7, so the cycle enable alone does not advance the counter.
- R2: The mode word has the ratio code n in bits 2:0 and the divider assignment in bit 3 (0 = counter, 1 = watchdog). Bit 4 is the edge select (0 = rising, 1 = falling) and bit 5 is the source (0 = cycle enable, 1 = pin).
- R3: When the divider serves the watchdog, the counter adds one for every source event and wraps from 0xFF to 0x00.
- R4: The overflow strobe is high for exactly the one cycle in which the counter first reads 0x00 after an increment from 0xFF.
- R5: A counter write loads the value on the next edge, takes priority over an increment in the same cycle, and raises no overflow strobe.
- R6: When the divider serves the counter, the counter advances once per 2^(n+1) source events, counted from the last divider clear.
- R7: When the divider serves the watchdog, the watchdog advances once per 2^n base ticks; otherwise it advances on every base tick. It expires on its 256th advance after a clear.
- R8: Expiry gives a reset pulse exactly one cycle long and sets the timeout flag, which stays set until reset.
- R9: The clear-watchdog strobe zeroes the watchdog count and wins over a tick in the same cycle. It clears the divider only while the divider serves the watchdog.
- R10: A counter write clears the divider only while the divider serves the counter.
- R11: A mode write that changes the assignment bit clears the divider.
- R12: In pin mode the pin passes through two synchronizing flops. A selected edge advances the counter on the third clock edge after the pin changes. The other edge and the cycle enable have no effect.
- R13: With the watchdog-enable configuration low the watchdog holds at zero and gives no pulse and no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_en | input | 1 | Instruction-cycle enable, one pulse per cycle |
| ext_pin | input | 1 | External count pin, asynchronous |
| wdt_tick | input | 1 | Watchdog base tick, one clock wide |
| wdt_clr | input | 1 | Clear-watchdog strobe |
| wdt_on | input | 1 | Configuration: watchdog permanently enabled |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 6 | Mode register write data |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter write data |
| cnt_val | output | 8 | Current counter value |
| cnt_ovf | output | 1 | One-cycle counter wrap strobe |
| wdt_rst | output | 1 | One-cycle watchdog reset pulse |
| wdt_flag | output | 1 | Sticky watchdog timeout flag |

## Verification
The assertions take it that reset is held for at least two clock edges, so values sampled in the last reset cycle are defined. They also take `wdt_on` as static between resets. The stimulus changes `wdt_on` only while no tick is pending and checks the effect at the ports, and every reset it applies lasts three edges. The stimulus drives `cyc_en` and `wdt_tick` one clock wide or held high, and it changes the pin only after the synchronizer has settled.

// File: rtl/tmr_pkg.sv
// Shared types for the timer/watchdog unit.
// Assumes a 3-bit ratio code; the divider width follows from it.
package tmr_pkg;
    localparam int TMR_RATIO_W = 3;
    localparam int TMR_MODE_W  = TMR_RATIO_W + 3;

    typedef struct packed {
        logic                   src_pin;    // bit 5: 1 = external pin
        logic                   fall_edge;  // bit 4: 1 = falling edge counts
        logic                   ps_to_wdt;  // bit 3: 1 = divider serves watchdog
        logic [TMR_RATIO_W-1:0] ratio;      // bits 2:0
    } tmr_mode_t;

    localparam tmr_mode_t TMR_MODE_RST = '{src_pin: 1'b1, fall_edge: 1'b1,
                                           ps_to_wdt: 1'b1, ratio: '1};
endpackage

// File: rtl/tmr_pin_edge.sv
// Pin synchronizer and edge detector.
// Two flops bring the asynchronous pin into the clk domain. A third flop
// holds the previous value. evt_o is high for one cycle per selected edge.
module tmr_pin_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic fall_sel_i,
    output logic evt_o
);
    logic s1_q, s2_q, prev_q;

    // Synchronize the pin and keep its previous value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            s1_q   <= pin_i;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    // Select the rising or the falling transition.
    always_comb begin
        if (fall_sel_i) evt_o = prev_q & ~s2_q;
        else            evt_o = s2_q & ~prev_q;
    end
endmodule

// File: rtl/tmr_prescaler.sv
// Shared power-of-two divider.
// The divider shift is ratio_i, plus one when the divider serves the
// counter. tick_o fires on every 2^shift-th input tick after a clear.
// Assumes PS_W = 2**RATIO_W, so the largest shift fits the divider.
module tmr_prescaler #(
    parameter int RATIO_W = 3,
    parameter int PS_W    = 2 ** RATIO_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               clr_i,
    input  logic               for_cnt_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               tick_o
);
    localparam int SHW = RATIO_W + 1;

    logic [PS_W-1:0] ps_q;
    logic [PS_W-1:0] mask;
    logic [SHW-1:0]  shift;

    assign shift = {1'b0, ratio_i} + {{RATIO_W{1'b0}}, for_cnt_i};

    // Build the low-bit mask one bit per divider stage.
    for (genvar i = 0; i < PS_W; i++) begin : g_mask
        assign mask[i] = (shift > SHW'(i));
    end

    assign tick_o = tick_i && ((ps_q & mask) == mask);

    // Free-running divider with a synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) ps_q <= '0;
        else if (tick_i)     ps_q <= ps_q + 1'b1;
    end

    a_r11_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (ps_q == '0));
endmodule

// File: rtl/tmr_watchdog.sv
// Watchdog counter.
// The count advances on inc_i and expires on wrap. Expiry gives a
// one-cycle reset pulse and sets a sticky flag. Assumes en_i is static
// between resets.
module tmr_watchdog #(
    parameter int WDT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic inc_i,
    input  logic clr_i,
    output logic rst_o,
    output logic flag_o
);
    logic [WDT_W-1:0] cnt_q;
    logic             expire;

    assign expire = en_i && inc_i && !clr_i && (&cnt_q);

    // Count base events; clear on strobe or while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i || clr_i) cnt_q <= '0;
        else if (inc_i)               cnt_q <= cnt_q + 1'b1;
    end

    // Register the expiry pulse and hold the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_o  <= 1'b0;
            flag_o <= 1'b0;
        end else begin
            rst_o  <= expire;
            flag_o <= flag_o | expire;
        end
    end

    a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        rst_o |=> !rst_o);
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o |=> flag_o);
    a_r13_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !rst_o);
endmodule

// File: rtl/tmr_wdt_unit.sv
// Timer with shared watchdog prescaler (top level).
// Holds the mode register and the counter, and routes the one divider
// to the counter or the watchdog. Assumes cyc_en and wdt_tick are
// clk-domain pulses and ext_pin may be asynchronous.
module tmr_wdt_unit
    import tmr_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int WDT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cyc_en,
    input  logic                  ext_pin,
    input  logic                  wdt_tick,
    input  logic                  wdt_clr,
    input  logic                  wdt_on,
    input  logic                  mode_we,
    input  logic [TMR_MODE_W-1:0] mode_wdata,
    input  logic                  cnt_we,
    input  logic [CNT_W-1:0]      cnt_wdata,
    output logic [CNT_W-1:0]      cnt_val,
    output logic                  cnt_ovf,
    output logic                  wdt_rst,
    output logic                  wdt_flag
);
    localparam int PS_W = 2 ** TMR_RATIO_W;

    tmr_mode_t        mode_q, mode_new;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;
    logic             pin_evt, src_evt, ps_in, ps_out, ps_clr;
    logic             cnt_inc, wdt_inc;

    assign mode_new = tmr_mode_t'(mode_wdata);

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= TMR_MODE_RST;
        else if (mode_we) mode_q <= mode_new;
    end

    tmr_pin_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (ext_pin),
        .fall_sel_i (mode_q.fall_edge),
        .evt_o      (pin_evt)
    );

    // Pick the counter source and route the divider.
    always_comb begin
        src_evt = mode_q.src_pin ? pin_evt : cyc_en;
        if (mode_q.ps_to_wdt) begin
            ps_in   = wdt_tick;
            wdt_inc = ps_out;
            cnt_inc = src_evt;
        end else begin
            ps_in   = src_evt;
            cnt_inc = ps_out;
            wdt_inc = wdt_tick;
        end
        ps_clr = (cnt_we && !mode_q.ps_to_wdt)
              || (wdt_clr && mode_q.ps_to_wdt)
              || (mode_we && (mode_new.ps_to_wdt != mode_q.ps_to_wdt));
    end

    tmr_prescaler #(.RATIO_W(TMR_RATIO_W), .PS_W(PS_W)) u_ps (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (ps_in),
        .clr_i     (ps_clr),
        .for_cnt_i (!mode_q.ps_to_wdt),
        .ratio_i   (mode_q.ratio),
        .tick_o    (ps_out)
    );

    // Counter with write priority and the wrap strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= cnt_inc && !cnt_we && (&cnt_q);
            if (cnt_we)       cnt_q <= cnt_wdata;
            else if (cnt_inc) cnt_q <= cnt_q + 1'b1;
        end
    end

    tmr_watchdog #(.WDT_W(WDT_W)) u_wdt (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (wdt_on),
        .inc_i  (wdt_inc),
        .clr_i  (wdt_clr),
        .rst_o  (wdt_rst),
        .flag_o (wdt_flag)
    );

    assign cnt_val = cnt_q;
    assign cnt_ovf = ovf_q;

    a_r4_ovf_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_ovf |-> (cnt_q == '0));
    a_r4_ovf_single: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_ovf |=> !cnt_ovf);
    a_r3_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_we |=> (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
endmodule

// File: tb/tb_tmr_wdt_unit.sv
// Scoreboard bench. Driver tasks queue expected items; a monitor pops
// and compares them at the falling clock edge.
module tb_tmr_wdt_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en = 1'b0, ext_pin = 1'b0, wdt_tick = 1'b0;
    logic       wdt_clr = 1'b0, wdt_on = 1'b1;
    logic       mode_we = 1'b0, cnt_we = 1'b0;
    logic [5:0] mode_wdata = '0;
    logic [7:0] cnt_wdata = '0;
    logic [7:0] cnt_val;
    logic       cnt_ovf, wdt_rst, wdt_flag;

    typedef struct {
        int    sig;
        int    exp;
        string req;
    } item_t;
    item_t sb_q[$];
    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;

    always #5 clk = ~clk;

    tmr_wdt_unit dut (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_pin(ext_pin),
        .wdt_tick(wdt_tick), .wdt_clr(wdt_clr), .wdt_on(wdt_on),
        .mode_we(mode_we), .mode_wdata(mode_wdata), .cnt_we(cnt_we),
        .cnt_wdata(cnt_wdata), .cnt_val(cnt_val), .cnt_ovf(cnt_ovf),
        .wdt_rst(wdt_rst), .wdt_flag(wdt_flag)
    );

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input int sig, input int exp, input string req);
        item_t it;
        it.sig = sig; it.exp = exp; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cyc_en = 0; ext_pin = 0; wdt_tick = 0; wdt_clr = 0;
        mode_we = 0; cnt_we = 0;
        step(3);
        rst_n = 1'b1;
    endtask

    task automatic wr_mode(input logic [5:0] m);
        mode_we = 1'b1; mode_wdata = m;
        step(1);
        mode_we = 1'b0;
    endtask

    task automatic wr_cnt(input logic [7:0] v);
        cnt_we = 1'b1; cnt_wdata = v;
        step(1);
        cnt_we = 1'b0;
    endtask

    // Monitor: compare every queued item against the outputs.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            int    act;
            it = sb_q.pop_front();
            case (it.sig)
                0:       act = int'(cnt_val);
                1:       act = int'(cnt_ovf);
                2:       act = int'(wdt_rst);
                default: act = int'(wdt_flag);
            endcase
            checks++;
            if (act != it.exp) begin
                failures++;
                $display("FAIL %s sig=%0d actual=%0h expected=%0h", it.req, it.sig, act, it.exp);
            end
        end
    end

    // Watchdog for a hung run.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset values, and the reset mode ignores cyc_en
        chk(0, 0, "R1"); chk(1, 0, "R1"); chk(2, 0, "R1"); chk(3, 0, "R1");
        cyc_en = 1; step(4); chk(0, 0, "R1"); cyc_en = 0;

        // R2 R3: divider to watchdog, counter counts cycle enables directly
        wr_mode(6'h08);
        wr_cnt(8'hFC); chk(0, 8'hFC, "R5");
        cyc_en = 1;
        step(1); chk(0, 8'hFD, "R3"); chk(1, 0, "R4");
        step(1); chk(0, 8'hFE, "R2");
        step(1); chk(0, 8'hFF, "R3");
        step(1); chk(0, 8'h00, "R3"); chk(1, 1, "R4");
        step(1); chk(0, 8'h01, "R4"); chk(1, 0, "R4");
        cnt_we = 1; cnt_wdata = 8'h10; step(1); chk(0, 8'h10, "R5");
        cnt_wdata = 8'hFF; step(1); chk(0, 8'hFF, "R5"); chk(1, 0, "R5");
        cnt_we = 0; step(1); chk(0, 8'h00, "R4"); chk(1, 1, "R4");
        cyc_en = 0;

        // R6 R11: divider to counter at 1:2
        wr_mode(6'h00);
        wr_cnt(8'h00);
        cyc_en = 1;
        step(1); chk(0, 0, "R6");
        step(1); chk(0, 1, "R6");
        step(4); chk(0, 3, "R6");
        step(1); cyc_en = 0;
        wdt_clr = 1; step(1); wdt_clr = 0;   // R9: must not clear the divider
        cyc_en = 1; step(1); chk(0, 4, "R9"); cyc_en = 0;
        cyc_en = 1; step(1); cyc_en = 0;
        wr_cnt(8'h20);                        // R10: clears the divider
        cyc_en = 1;
        step(1); chk(0, 8'h20, "R10");
        step(1); chk(0, 8'h21, "R10");
        step(1); cyc_en = 0;
        wr_mode(6'h08); wr_mode(6'h00);       // R11: assignment change clears
        cyc_en = 1;
        step(1); chk(0, 8'h21, "R11");
        step(1); chk(0, 8'h22, "R11");
        cyc_en = 0;
        wr_mode(6'h02); wr_cnt(8'h00);        // 1:8
        cyc_en = 1;
        step(7); chk(0, 0, "R6");
        step(1); chk(0, 1, "R6");
        cyc_en = 0;
        wr_mode(6'h07); wr_cnt(8'h00);        // 1:256
        cyc_en = 1;
        step(255); chk(0, 0, "R6");
        step(1); chk(0, 1, "R6");
        cyc_en = 0;

        // R7 R8 R9: watchdog without the divider
        wdt_clr = 1; step(1); wdt_clr = 0;
        wdt_tick = 1; step(200);
        wdt_clr = 1; step(1); wdt_clr = 0;
        step(255); chk(2, 0, "R9"); chk(3, 0, "R9");
        step(1); chk(2, 1, "R7"); chk(3, 1, "R8");
        step(1); chk(2, 0, "R8"); chk(3, 1, "R8");
        wdt_tick = 0;

        // R7: divider to watchdog, code 0 divides 1:1
        do_reset();
        wr_mode(6'h08);
        wdt_tick = 1;
        step(255); chk(2, 0, "R7");
        step(1); chk(2, 1, "R7");
        wdt_tick = 0;

        // R7: code 1 divides 1:2 for the watchdog
        do_reset();
        wr_mode(6'h09);
        wdt_clr = 1; step(1); wdt_clr = 0;
        wdt_tick = 1;
        step(511); chk(2, 0, "R7"); chk(3, 0, "R7");
        step(1); chk(2, 1, "R7"); chk(3, 1, "R8");
        step(1);                              // divider left odd
        wdt_tick = 0;
        wdt_clr = 1; step(1); wdt_clr = 0;    // R9: clears divider too
        wdt_tick = 1;
        step(511); chk(2, 0, "R9");
        step(1); chk(2, 1, "R9");
        wdt_tick = 0;

        // R13: watchdog disabled by configuration
        do_reset();
        wdt_on = 0;
        wr_mode(6'h00);
        wdt_tick = 1; step(300); chk(2, 0, "R13"); chk(3, 0, "R13");
        wdt_tick = 0; wdt_on = 1;
        wdt_tick = 1; step(255); chk(2, 0, "R13");
        step(1); chk(2, 1, "R13");
        wdt_tick = 0;

        // R12: external pin, rising then falling selection
        do_reset();
        wr_mode(6'h28); wr_cnt(8'h00);
        cyc_en = 1;
        ext_pin = 1; step(2); chk(0, 0, "R12");
        step(1); chk(0, 1, "R12");
        step(3); chk(0, 1, "R12");
        ext_pin = 0; step(4); chk(0, 1, "R12");
        wr_mode(6'h38);
        ext_pin = 1; step(4); chk(0, 1, "R12");
        ext_pin = 0; step(2); chk(0, 1, "R12");
        step(1); chk(0, 2, "R12");
        cyc_en = 0;

        step(2);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule